// File: doc/BRIEF.md
# Bidirectional Two-State Trellis Soft Decoder for a Six-Bit Parity Check

This block computes extrinsic soft messages for one even-parity check that ties together six bits. It takes six 4-bit two's complement log-likelihood inputs and returns, for each bit, a soft estimate built from the other five. The check is seen as a two-state trellis with six stages. The state is the running parity. The state metric is kept as one signed difference value.

Two recursions run at the same time. A forward unit starts at the left end of the trellis and a backward unit starts at the right end. Each takes one branch metric per cycle for three cycles. Each pushes its previous state metric, together with the branch metric it just used, onto its own stack. From the midpoint on, the stacks are popped in reverse order. Two output units then pair each popped metric with the live metric of the opposite recursion. Meanwhile the recursions continue past the midpoint, using the branch metrics kept on the opposite stack. Two extrinsic values come out per cycle for three cycles, and a done pulse follows.

Top module: `siso_parity_trellis`

## Requirements
- R1: After reset, and whenever no decode is in flight, `ext_valid_o` and `done_o` are low.
- R2: Every processing unit computes Q(x,y) = sat(s·min(|x|,|y|) + g(|x+y|) − g(|x−y|)). Here s is −1 when exactly one operand is negative and +1 otherwise, g(d) = 1 for d < 2 and 0 otherwise, and sat clamps the result to the 4-bit range [−8, 7].
- R3: A decode is accepted on a clock edge where `start_i` is high and the unit is idle. That edge takes λ0 on `lam_fwd_i` and λ5 on `lam_bwd_i`. The next two edges take λ1/λ4 and then λ2/λ3. Input values on any other edge have no effect.
- R4: With α0 = β6 = +7, α(k+1) = Q(α(k), λk) and β(k) = Q(β(k+1), λk), the extrinsic output for bit i equals Q(α(i), β(i+1)).
- R5: `ext_valid_o` is high for exactly the 3rd, 4th and 5th cycles after the accepting edge. In those cycles `ext_hi_o` carries bits 3, 4, 5 and `ext_lo_o` carries bits 2, 1, 0, in that order.
- R6: `done_o` is high for exactly one cycle, the cycle right after the last output pair, and `ext_valid_o` is low in that cycle.
- R7: `start_i` is ignored from the accepting edge through the done cycle. Holding it high changes neither the outputs nor the valid/done timing, and no new decode starts from it.
- R8: A new decode can be accepted on the edge that ends the done cycle's following idle cycle, so decodes run back to back every seven cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, taken only when idle |
| lam_fwd_i | input | MSG_W | Branch metric for the forward recursion |
| lam_bwd_i | input | MSG_W | Branch metric for the backward recursion |
| ext_hi_o | output | MSG_W | Extrinsic output for the upper-half bit |
| ext_lo_o | output | MSG_W | Extrinsic output for the lower-half bit |
| ext_valid_o | output | 1 | Output pair valid |
| done_o | output | 1 | One-cycle end-of-decode pulse |

## Verification
The bench builds the block with its defaults: 4-bit messages and six stages. That width keeps every input value within reach. The bench sweeps all sixteen values at each bit position over eight background levels, runs every all-equal input set, and adds several thousand random sets. This covers saturation at −8 and +7, zero operands and the correction band near zero. Holding start high through whole decodes and driving unrelated values on the input ports during output cycles shows that starts while busy, and off-schedule inputs, have no effect.

// File: rtl/siso_trellis_pkg.sv
package siso_trellis_pkg;
  localparam int unsigned MSG_W_DEF  = 4;
  localparam int unsigned STAGES_DEF = 6;
  // correction term applies when the combined magnitude is below this
  localparam int unsigned CORR_LIMIT = 2;
endpackage

// File: rtl/quartet_unit.sv
module quartet_unit
  import siso_trellis_pkg::*;
#(
  parameter int unsigned W = MSG_W_DEF
) (
  input  logic signed [W-1:0] x_i,
  input  logic signed [W-1:0] y_i,
  output logic signed [W-1:0] q_o
);
  localparam int XW = W + 2;
  localparam logic signed [XW-1:0] MAXV = XW'((1 <<< (W-1)) - 1);
  localparam logic signed [XW-1:0] MINV = -MAXV - XW'(1);
  localparam logic signed [XW-1:0] LIM  = XW'(CORR_LIMIT);

  logic signed [XW-1:0] xs, ys, sum, dif, mx, base, dp, dm, cp, cm, r;

  always_comb begin
    xs   = XW'(x_i);
    ys   = XW'(y_i);
    sum  = xs + ys;
    dif  = xs - ys;
    mx   = (xs > ys) ? xs : ys;
    // max(x+y,0) - max(x,y): signed-min core
    base = ((sum > 0) ? sum : '0) - mx;
    dp   = (sum < 0) ? -sum : sum;
    dm   = (dif < 0) ? -dif : dif;
    cp   = (dp < LIM) ? XW'(1) : '0;
    cm   = (dm < LIM) ? XW'(1) : '0;
    r    = base + cp - cm;
    if (r > MAXV)      q_o = MAXV[W-1:0];
    else if (r < MINV) q_o = MINV[W-1:0];
    else               q_o = r[W-1:0];
  end
endmodule

// File: rtl/metric_stack.sv
module metric_stack #(
  parameter int unsigned EW    = 8,
  parameter int unsigned DEPTH = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [EW-1:0] din_i,
  output logic [EW-1:0] top_o
);
  localparam int PW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [EW-1:0] mem_q [DEPTH];
  logic [PW-1:0] sp_q;
  logic [IW-1:0] wr_idx, top_idx;

  assign wr_idx  = IW'(sp_q);
  assign top_idx = IW'(sp_q - PW'(1));
  assign top_o   = mem_q[top_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q <= '0;
    end else if (push_i) begin
      sp_q <= sp_q + PW'(1);
    end else if (pop_i) begin
      sp_q <= sp_q - PW'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_idx] <= din_i;
  end

  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (sp_q < PW'(DEPTH)));
  a_r3_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (sp_q != '0));
  a_r3_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && pop_i));
endmodule

// File: rtl/siso_parity_trellis.sv
module siso_parity_trellis
  import siso_trellis_pkg::*;
#(
  parameter int unsigned MSG_W  = MSG_W_DEF,
  parameter int unsigned STAGES = STAGES_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [MSG_W-1:0] lam_fwd_i,
  input  logic [MSG_W-1:0] lam_bwd_i,
  output logic [MSG_W-1:0] ext_hi_o,
  output logic [MSG_W-1:0] ext_lo_o,
  output logic             ext_valid_o,
  output logic             done_o
);
  localparam int unsigned HALF = STAGES / 2;
  localparam int PH_W = $clog2(STAGES + 1);
  localparam int EW   = 2 * MSG_W;
  localparam logic signed [MSG_W-1:0] INIT = {1'b0, {(MSG_W-1){1'b1}}};

  logic [PH_W-1:0] phase_q;
  logic accept, loading, emitting;
  logic signed [MSG_W-1:0] alpha_q, beta_q;

  // index 0: forward, 1: backward
  logic signed [MSG_W-1:0] rec_a [2];
  logic signed [MSG_W-1:0] rec_b [2];
  logic signed [MSG_W-1:0] rec_q [2];
  logic [EW-1:0]           stk_top [2];
  logic signed [MSG_W-1:0] top_met [2];
  logic signed [MSG_W-1:0] top_lam [2];

  assign accept   = start_i && (phase_q == '0);
  assign loading  = accept || ((phase_q != '0) && (phase_q < PH_W'(HALF)));
  assign emitting = (phase_q >= PH_W'(HALF)) && (phase_q < PH_W'(STAGES));

  assign rec_a[0] = accept ? INIT : alpha_q;
  assign rec_a[1] = accept ? INIT : beta_q;
  // past the midpoint each recursion consumes the metric stored by the other
  assign rec_b[0] = loading ? $signed(lam_fwd_i) : top_lam[1];
  assign rec_b[1] = loading ? $signed(lam_bwd_i) : top_lam[0];

  for (genvar d = 0; d < 2; d++) begin : g_dir
    quartet_unit #(.W(MSG_W)) u_rec (
      .x_i (rec_a[d]),
      .y_i (rec_b[d]),
      .q_o (rec_q[d])
    );
    metric_stack #(.EW(EW), .DEPTH(HALF)) u_stk (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .push_i (loading),
      .pop_i  (emitting),
      .din_i  ({rec_a[d], rec_b[d]}),
      .top_o  (stk_top[d])
    );
    assign top_met[d] = $signed(stk_top[d][EW-1:MSG_W]);
    assign top_lam[d] = $signed(stk_top[d][MSG_W-1:0]);
  end

  logic signed [MSG_W-1:0] out_hi, out_lo;

  quartet_unit #(.W(MSG_W)) u_out_hi (
    .x_i (alpha_q),
    .y_i (top_met[1]),
    .q_o (out_hi)
  );
  quartet_unit #(.W(MSG_W)) u_out_lo (
    .x_i (top_met[0]),
    .y_i (beta_q),
    .q_o (out_lo)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      alpha_q <= '0;
      beta_q  <= '0;
    end else begin
      if (accept)
        phase_q <= PH_W'(1);
      else if (phase_q == PH_W'(STAGES))
        phase_q <= '0;
      else if (phase_q != '0)
        phase_q <= phase_q + PH_W'(1);
      if (loading || emitting) begin
        alpha_q <= rec_q[0];
        beta_q  <= rec_q[1];
      end
    end
  end

  assign ext_hi_o    = out_hi;
  assign ext_lo_o    = out_lo;
  assign ext_valid_o = emitting;
  assign done_o      = (phase_q == PH_W'(STAGES));

  function automatic logic [MSG_W:0] mag(input logic signed [MSG_W-1:0] v);
    logic signed [MSG_W:0] e;
    e = {v[MSG_W-1], v};
    return (e < 0) ? -e : e;
  endfunction

  a_r6_done_after_pairs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(ext_valid_o) && !ext_valid_o));
  a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r5_valid_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_valid_o |=> (ext_valid_o || done_o));
  a_r7_busy_advances: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != '0) |=> ((phase_q == '0) ? ($past(phase_q) == PH_W'(STAGES))
                                         : (phase_q == $past(phase_q) + PH_W'(1))));
  a_r2_hi_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_valid_o |-> ({1'b0, mag(out_hi)} <= {1'b0, mag(top_met[1])} + (MSG_W+2)'(1)));
  a_r2_lo_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_valid_o |-> ({1'b0, mag(out_lo)} <= {1'b0, mag(top_met[0])} + (MSG_W+2)'(1)));
endmodule

// File: tb/siso_parity_trellis_tb.sv
module siso_parity_trellis_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] lam_f = '0;
  logic [3:0] lam_b = '0;
  logic [3:0] ext_hi, ext_lo;
  logic       ext_valid, done;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  siso_parity_trellis dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_i     (start),
    .lam_fwd_i   (lam_f),
    .lam_bwd_i   (lam_b),
    .ext_hi_o    (ext_hi),
    .ext_lo_o    (ext_lo),
    .ext_valid_o (ext_valid),
    .done_o      (done)
  );

  function automatic int sat4(input int v);
    if (v > 7) return 7;
    if (v < -8) return -8;
    return v;
  endfunction

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  // R2: sign-times-min plus correction, saturated
  function automatic int qref(input int x, input int y);
    int s, m, c;
    s = ((x < 0) != (y < 0)) ? -1 : 1;
    m = (iabs(x) < iabs(y)) ? iabs(x) : iabs(y);
    c = ((iabs(x + y) < 2) ? 1 : 0) - ((iabs(x - y) < 2) ? 1 : 0);
    return sat4(s * m + c);
  endfunction

  function automatic int s4(input logic [3:0] v);
    return int'($signed(v));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic decode(input int l[6], input bit hold);
    int a[7], b[7], e[6];
    a[0] = 7;
    b[6] = 7;
    for (int k = 0; k < 6; k++) a[k+1] = qref(a[k], l[k]);
    for (int k = 5; k >= 0; k--) b[k] = qref(b[k+1], l[k]);
    for (int i = 0; i < 6; i++) e[i] = qref(a[i], b[i+1]);

    @(negedge clk);
    chk(!ext_valid && !done, "R1 idle before start", int'(ext_valid), 0);
    start = 1'b1; lam_f = 4'(l[0]); lam_b = 4'(l[5]);
    @(negedge clk);
    chk(!ext_valid, "R5 no valid during load", int'(ext_valid), 0);
    start = hold; lam_f = 4'(l[1]); lam_b = 4'(l[4]);
    @(negedge clk);
    lam_f = 4'(l[2]); lam_b = 4'(l[3]);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      // R3: off-schedule inputs must not matter
      lam_f = 4'($urandom_range(15)); lam_b = 4'($urandom_range(15));
      chk(ext_valid && !done, "R5 valid window", int'(ext_valid), 1);
      chk(s4(ext_hi) == e[3+k], "R2,R4 hi output", s4(ext_hi), e[3+k]);
      chk(s4(ext_lo) == e[2-k], "R2,R4 lo output", s4(ext_lo), e[2-k]);
    end
    @(negedge clk);
    chk(done && !ext_valid, "R6 done pulse", int'(done), 1);
    if (hold) begin
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        chk(!ext_valid && !done, "R7 start while busy ignored", int'(ext_valid), 0);
      end
    end else begin
      start = 1'b0;
    end
  endtask

  initial begin
    int l[6];
    int bg[8] = '{-8, -5, -2, -1, 0, 1, 3, 7};
    repeat (3) @(negedge clk);
    chk(!ext_valid && !done, "R1 in reset", int'(ext_valid), 0);
    rst_n = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk(!ext_valid && !done, "R1 after reset", int'(done), 0);
    end
    // uniform inputs
    for (int v = -8; v < 8; v++) begin
      for (int k = 0; k < 6; k++) l[k] = v;
      decode(l, 1'b0);
    end
    // one position swept over a fixed background, back to back (R8)
    for (int g = 0; g < 8; g++)
      for (int p = 0; p < 6; p++)
        for (int v = -8; v < 8; v++) begin
          for (int k = 0; k < 6; k++) l[k] = bg[g];
          l[p] = v;
          decode(l, 1'b0);
        end
    // random sets, some with start held through the decode (R7)
    for (int n = 0; n < 3000; n++) begin
      for (int k = 0; k < 6; k++) l[k] = int'($urandom_range(15)) - 8;
      decode(l, (n % 8) == 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 190000);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule